// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This block keeps the two-bit processor control word and two stack pointer registers: the main one and the process one. The current execution mode and the stored stack-select bit decide which pointer is active. Handler mode always works on the main pointer. In thread mode the select bit picks between the two. The block tracks the mode itself. An exception entry strobe moves it into handler mode. An exception return strobe, together with its return code, moves it back to handler or thread mode and updates the select bit.

Software reaches the control word through a CSR-style port. A privilege input qualifies each access. Unprivileged accesses are discarded and flagged. The core reads and writes the active stack pointer through a separate port, and every stored pointer is forced to word alignment. The block also drives the thread-mode privilege level and the select bit captured at the last exception entry, so the core can build the return code.

Top module: `spctl_top`

## Requirements
- R1: After reset the block is in thread mode (`handler_mode`=0), the select bit and the thread-privilege bit are 0, both stack pointers hold their reset values (default 0), and `access_fault` and `bad_return` are 0.
- R2: The control word places the select bit at bit 1 (1 = process pointer) and the thread-privilege bit at bit 0 (1 = unprivileged code allowed). A privileged write in thread mode loads both bits. Bits 31:2 read as 0 and ignore writes.
- R3: In handler mode the main pointer is active (`psp_active`=0) whatever the stored select bit holds, and `sp_rdata` returns the main pointer.
- R4: In handler mode a write does not change the select bit and a read returns 0 in bit 1. Bit 0 is still written and read normally.
- R5: When `csr_priv`=0, `csr_rdata` is 0 and a write changes nothing. An unprivileged write makes `access_fault` high for exactly the one cycle after the write.
- R6: A return code of 0xFFFFFFF1 enters handler mode and leaves the select bit unchanged. 0xFFFFFFF9 enters thread mode and clears the select bit. 0xFFFFFFFD enters thread mode and sets the select bit.
- R7: Any other return code leaves the mode and the select bit unchanged, and makes `bad_return` high for the one cycle after the strobe.
- R8: Exception entry puts the block in handler mode and keeps the stored select bit. `sel_at_entry` then holds the select bit as it was in the entry cycle.
- R9: A stack pointer write goes to the active bank with bits 1:0 forced to 0. `csr_rdata` is combinational, and `sp_rdata` always shows the active bank.
- R10: When a privileged write and a valid exception return happen in the same cycle, the select bit comes from the return code and bit 0 comes from the write.
- R11: When exception entry and exception return happen in the same cycle, the entry wins. The return is ignored and raises no `bad_return`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_rd_en | input | 1 | Control word read request |
| csr_wr_en | input | 1 | Control word write request |
| csr_priv | input | 1 | Access is from privileged software |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control word read data (combinational) |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| exc_code | input | 32 | Return code sampled with `exc_return` |
| sp_wr_en | input | 1 | Write the active stack pointer |
| sp_wdata | input | SP_W | Stack pointer write data |
| sp_rdata | output | SP_W | Active stack pointer value |
| handler_mode | output | 1 | 1 = handler mode, 0 = thread mode |
| psp_active | output | 1 | Process pointer is the active one |
| thread_unpriv | output | 1 | Thread-mode privilege bit |
| sel_at_entry | output | 1 | Select bit captured at the last entry |
| access_fault | output | 1 | One-cycle pulse after an unprivileged write |
| bad_return | output | 1 | One-cycle pulse after an invalid return code |

## Verification
The assertions assume that `exc_code` is meaningful only while `exc_return` is high. They also assume that the privilege input is a plain qualifier the block never checks against its own thread-privilege bit, so a privileged access from thread mode with bit 0 set is legal. The stimulus drives every input on the falling edge and holds it for one whole cycle. It forms each return code from the three valid values plus one invalid value. It pairs entry, return and software writes in the same cycle only on purpose, so that the priority rules are exercised.

// File: rtl/spctl_pkg.sv
package spctl_pkg;

    localparam int CSR_W    = 32;
    localparam int SEL_BIT  = 1;
    localparam int PRIV_BIT = 0;

    localparam logic [CSR_W-1:0] RET_HANDLER_MAIN = 32'hFFFF_FFF1;
    localparam logic [CSR_W-1:0] RET_THREAD_MAIN  = 32'hFFFF_FFF9;
    localparam logic [CSR_W-1:0] RET_THREAD_PROC  = 32'hFFFF_FFFD;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;

    typedef struct packed {
        logic stk_sel;
        logic thr_unpriv;
    } ctl_bits_t;

    typedef struct packed {
        logic       valid;
        exec_mode_e mode;
        logic       set_sel;
        logic       sel_val;
    } ret_dec_t;

    function automatic ret_dec_t decode_return(input logic [CSR_W-1:0] code);
        ret_dec_t d;
        d = '{valid: 1'b0, mode: MODE_HANDLER, set_sel: 1'b0, sel_val: 1'b0};
        case (code)
            RET_HANDLER_MAIN: d = '{valid: 1'b1, mode: MODE_HANDLER, set_sel: 1'b0, sel_val: 1'b0};
            RET_THREAD_MAIN:  d = '{valid: 1'b1, mode: MODE_THREAD,  set_sel: 1'b1, sel_val: 1'b0};
            RET_THREAD_PROC:  d = '{valid: 1'b1, mode: MODE_THREAD,  set_sel: 1'b1, sel_val: 1'b1};
            default:          d = '{valid: 1'b0, mode: MODE_HANDLER, set_sel: 1'b0, sel_val: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic [CSR_W-1:0] pack_ctl(input ctl_bits_t c, input exec_mode_e m);
        logic [CSR_W-1:0] v;
        v = '0;
        v[SEL_BIT]  = (m == MODE_HANDLER) ? 1'b0 : c.stk_sel;
        v[PRIV_BIT] = c.thr_unpriv;
        return v;
    endfunction

endpackage

// File: rtl/spctl_ctrl.sv
module spctl_ctrl
    import spctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_en,
    input  logic             csr_priv,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             exc_entry,
    input  logic             exc_return,
    input  logic [CSR_W-1:0] exc_code,
    output exec_mode_e       mode_q,
    output ctl_bits_t        ctl_q,
    output logic             sel_cap_q,
    output logic             fault_q,
    output logic             bad_q
);

    exec_mode_e mode_d;
    ctl_bits_t  ctl_d;
    logic       cap_d;
    logic       wr_ok;
    ret_dec_t   dec;

    always_comb begin
        dec    = decode_return(exc_code);
        wr_ok  = csr_wr_en && csr_priv;
        mode_d = mode_q;
        ctl_d  = ctl_q;
        cap_d  = sel_cap_q;
        if (wr_ok) begin
            ctl_d.thr_unpriv = csr_wdata[PRIV_BIT];
            if (mode_q == MODE_THREAD) begin
                ctl_d.stk_sel = csr_wdata[SEL_BIT];
            end
        end
        if (exc_entry) begin
            mode_d = MODE_HANDLER;
            cap_d  = ctl_q.stk_sel;
        end else if (exc_return && dec.valid) begin
            mode_d = dec.mode;
            if (dec.set_sel) begin
                ctl_d.stk_sel = dec.sel_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_THREAD;
            ctl_q     <= '0;
            sel_cap_q <= 1'b0;
            fault_q   <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            ctl_q     <= ctl_d;
            sel_cap_q <= cap_d;
            fault_q   <= csr_wr_en && !csr_priv;
            bad_q     <= exc_return && !exc_entry && !dec.valid;
        end
    end

    // R8: entry lands in handler mode and captures the prior select bit
    a_r8_entry_capture: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> (mode_q == MODE_HANDLER) && (sel_cap_q == $past(ctl_q.stk_sel)));

    // R5: an unprivileged write alone leaves the control word untouched
    a_r5_unpriv_dropped: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && !csr_priv && !exc_entry && !exc_return) |=> ($stable(ctl_q) && fault_q));

    // R4: in handler mode only a return can move the select bit
    a_r4_handler_sel_locked: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HANDLER && !exc_return) |=> $stable(ctl_q.stk_sel));

    // R7: invalid code in handler mode keeps mode and select bit
    a_r7_bad_return_holds: assert property (@(posedge clk) disable iff (rst)
        (exc_return && !exc_entry && mode_q == MODE_HANDLER && !decode_return(exc_code).valid)
        |=> (bad_q && $stable(mode_q) && $stable(ctl_q.stk_sel)));

    // R11: simultaneous entry and return never flags a bad return
    a_r11_entry_wins: assert property (@(posedge clk) disable iff (rst)
        (exc_entry && exc_return) |=> (!bad_q && mode_q == MODE_HANDLER));

endmodule

// File: rtl/spctl_sp_bank.sv
module spctl_sp_bank #(
    parameter int             SP_W      = 32,
    parameter logic [SP_W-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SP_W-1:0] wr_data,
    output logic [SP_W-1:0] sp_q
);

    localparam int ALIGN_BITS = 2;
    localparam logic [SP_W-1:0] ALIGN_MASK = {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= RESET_VAL & ALIGN_MASK;
        end else if (wr_en) begin
            sp_q <= wr_data & ALIGN_MASK;
        end
    end

endmodule

// File: rtl/spctl_csr_view.sv
module spctl_csr_view
    import spctl_pkg::*;
(
    input  logic             rd_en,
    input  logic             priv,
    input  exec_mode_e       mode,
    input  ctl_bits_t        ctl,
    output logic [CSR_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en && priv) begin
            rdata = pack_ctl(ctl, mode);
        end
    end

    // R4: handler-mode reads never expose the select bit
    always_comb begin
        a_r4_handler_reads_zero: assert (!(mode == MODE_HANDLER) || rdata[SEL_BIT] == 1'b0);
    end

    // R2: reserved bits always read as zero
    always_comb begin
        a_r2_reserved_zero: assert (rdata[CSR_W-1:2] == '0);
    end

endmodule

// File: rtl/spctl_top.sv
module spctl_top
    import spctl_pkg::*;
#(
    parameter int              SP_W          = 32,
    parameter logic [SP_W-1:0] MAIN_SP_RESET = '0,
    parameter logic [SP_W-1:0] PROC_SP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_rd_en,
    input  logic             csr_wr_en,
    input  logic             csr_priv,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    input  logic             exc_entry,
    input  logic             exc_return,
    input  logic [31:0]      exc_code,
    input  logic             sp_wr_en,
    input  logic [SP_W-1:0]  sp_wdata,
    output logic [SP_W-1:0]  sp_rdata,
    output logic             handler_mode,
    output logic             psp_active,
    output logic             thread_unpriv,
    output logic             sel_at_entry,
    output logic             access_fault,
    output logic             bad_return
);

    localparam int N_BANKS = 2;
    localparam int IDX_W   = $clog2(N_BANKS);
    localparam logic [IDX_W-1:0] IDX_MAIN = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PROC = IDX_W'(1);

    exec_mode_e       mode_q;
    ctl_bits_t        ctl_q;
    logic [IDX_W-1:0] act_idx;
    logic [SP_W-1:0]  bank_q [N_BANKS];

    spctl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .csr_wr_en  (csr_wr_en),
        .csr_priv   (csr_priv),
        .csr_wdata  (csr_wdata),
        .exc_entry  (exc_entry),
        .exc_return (exc_return),
        .exc_code   (exc_code),
        .mode_q     (mode_q),
        .ctl_q      (ctl_q),
        .sel_cap_q  (sel_at_entry),
        .fault_q    (access_fault),
        .bad_q      (bad_return)
    );

    spctl_csr_view u_view (
        .rd_en (csr_rd_en),
        .priv  (csr_priv),
        .mode  (mode_q),
        .ctl   (ctl_q),
        .rdata (csr_rdata)
    );

    assign act_idx = (mode_q == MODE_THREAD && ctl_q.stk_sel) ? IDX_PROC : IDX_MAIN;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        localparam logic [SP_W-1:0] RV = (g == 0) ? MAIN_SP_RESET : PROC_SP_RESET;
        spctl_sp_bank #(
            .SP_W      (SP_W),
            .RESET_VAL (RV)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (sp_wr_en && (act_idx == IDX_W'(g))),
            .wr_data (sp_wdata),
            .sp_q    (bank_q[g])
        );
    end

    assign sp_rdata      = bank_q[act_idx];
    assign handler_mode  = (mode_q == MODE_HANDLER);
    assign psp_active    = (act_idx == IDX_PROC);
    assign thread_unpriv = ctl_q.thr_unpriv;

    // R3: a pointer write in handler mode never reaches the process bank
    a_r3_handler_main_only: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && sp_wr_en) |=> $stable(bank_q[IDX_PROC]));

    // R9: a lone pointer write reads back aligned on the same bank
    a_r9_sp_write_lands: assert property (@(posedge clk) disable iff (rst)
        (sp_wr_en && !exc_entry && !exc_return && !csr_wr_en)
        |=> (sp_rdata == {$past(sp_wdata[SP_W-1:2]), 2'b00}));

endmodule

// File: tb/sim_spctl_top.sv
`timescale 1ns/1ps
module sim_spctl_top;

    localparam int SP_W = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            csr_rd_en, csr_wr_en, csr_priv;
    logic [31:0]     csr_wdata, csr_rdata;
    logic            exc_entry, exc_return;
    logic [31:0]     exc_code;
    logic            sp_wr_en;
    logic [SP_W-1:0] sp_wdata, sp_rdata;
    logic            handler_mode, psp_active, thread_unpriv, sel_at_entry;
    logic            access_fault, bad_return;

    always #2 clk = ~clk;

    spctl_top u0 (
        .clk(clk), .rst(rst),
        .csr_rd_en(csr_rd_en), .csr_wr_en(csr_wr_en), .csr_priv(csr_priv),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .exc_entry(exc_entry), .exc_return(exc_return), .exc_code(exc_code),
        .sp_wr_en(sp_wr_en), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
        .handler_mode(handler_mode), .psp_active(psp_active),
        .thread_unpriv(thread_unpriv), .sel_at_entry(sel_at_entry),
        .access_fault(access_fault), .bad_return(bad_return)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_hand, m_sel, m_tmpl, m_cap, m_fault, m_bad;
    logic [31:0] m_main, m_proc;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input bit rd, input bit pv);
        logic [31:0] v = '0;
        if (rd && pv) begin
            v[1] = m_hand ? 1'b0 : m_sel;
            v[0] = m_tmpl;
        end
        return v;
    endfunction

    task automatic compare_regs(input string tag);
        bit use_proc = !m_hand && m_sel;
        check(tag, "handler_mode", {31'b0, handler_mode}, {31'b0, m_hand});
        check(tag, "psp_active", {31'b0, psp_active}, {31'b0, use_proc});
        check(tag, "thread_unpriv", {31'b0, thread_unpriv}, {31'b0, m_tmpl});
        check(tag, "sel_at_entry", {31'b0, sel_at_entry}, {31'b0, m_cap});
        check(tag, "access_fault", {31'b0, access_fault}, {31'b0, m_fault});
        check(tag, "bad_return", {31'b0, bad_return}, {31'b0, m_bad});
        check(tag, "sp_rdata", sp_rdata, use_proc ? m_proc : m_main);
    endtask

    // one cycle: inputs driven at negedge, combinational read checked, model advanced at posedge
    task automatic step(input string tag,
                        input bit rd, input bit wr, input bit pv, input logic [31:0] wd,
                        input bit ent, input bit ret, input logic [31:0] code,
                        input bit spw, input logic [31:0] spd);
        bit valid, to_hand, sets, sv, old_hand;
        csr_rd_en = rd; csr_wr_en = wr; csr_priv = pv; csr_wdata = wd;
        exc_entry = ent; exc_return = ret; exc_code = code;
        sp_wr_en = spw; sp_wdata = spd;
        #1;
        check(tag, "csr_rdata", csr_rdata, exp_rdata(rd, pv));
        @(posedge clk);
        valid = 1; to_hand = 0; sets = 0; sv = 0;
        if (code == 32'hFFFF_FFF1) begin to_hand = 1; end
        else if (code == 32'hFFFF_FFF9) begin sets = 1; sv = 0; end
        else if (code == 32'hFFFF_FFFD) begin sets = 1; sv = 1; end
        else valid = 0;
        old_hand = m_hand;
        if (spw) begin
            if (!old_hand && m_sel) m_proc = spd & 32'hFFFF_FFFC;
            else                    m_main = spd & 32'hFFFF_FFFC;
        end
        m_fault = wr && !pv;
        m_bad   = ret && !ent && !valid;
        if (ent) m_cap = m_sel;
        if (wr && pv) begin
            m_tmpl = wd[0];
            if (!old_hand) m_sel = wd[1];
        end
        if (ent) m_hand = 1;
        else if (ret && valid) begin
            m_hand = to_hand;
            if (sets) m_sel = sv;
        end
        @(negedge clk);
        compare_regs(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        csr_rd_en = 0; csr_wr_en = 0; csr_priv = 0; csr_wdata = 0;
        exc_entry = 0; exc_return = 0; exc_code = 0; sp_wr_en = 0; sp_wdata = 0;
        m_hand = 0; m_sel = 0; m_tmpl = 0; m_cap = 0; m_fault = 0; m_bad = 0;
        m_main = 0; m_proc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_regs("R1");
        idle("R1");

        // R9: write main pointer in thread mode, misaligned data
        step("R9", 1, 0, 1, 0, 0, 0, 0, 1, 32'h2000_1007);
        // R2: privileged write, reserved bits set
        step("R2", 1, 1, 1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
        step("R2", 1, 1, 1, 32'h0000_0003, 0, 0, 0, 0, 0);
        // R9: now on process bank
        step("R9", 1, 0, 1, 0, 0, 0, 0, 1, 32'h1000_0FFF);
        idle("R9");
        // R8: entry captures select bit 1
        step("R8", 1, 0, 1, 0, 1, 0, 0, 0, 0);
        // R3: handler writes the main pointer only
        step("R3", 1, 0, 1, 0, 0, 0, 0, 1, 32'h2000_0F02);
        // R4: try to clear bit 1 and bit 0 in handler mode
        step("R4", 1, 1, 1, 32'h0000_0000, 0, 0, 0, 0, 0);
        step("R4", 1, 1, 1, 32'h0000_0003, 0, 0, 0, 0, 0);
        // R5: unprivileged read and write
        step("R5", 1, 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0);
        idle("R5");
        // R7: invalid code
        step("R7", 1, 0, 1, 0, 0, 1, 32'hFFFF_FFF5, 0, 0);
        idle("R7");
        // R6: back to thread on process pointer
        step("R6", 1, 0, 1, 0, 0, 1, 32'hFFFF_FFFD, 0, 0);
        idle("R6");
        // R5 in thread mode
        step("R5", 1, 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0);
        // R8: entry with select set, then return to handler-main, then thread-main
        step("R8", 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step("R6", 1, 0, 1, 0, 0, 1, 32'hFFFF_FFF1, 0, 0);
        step("R6", 1, 0, 1, 0, 0, 1, 32'hFFFF_FFF9, 0, 0);
        idle("R6");
        // R10: write and return together
        step("R10", 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step("R10", 1, 1, 1, 32'h0000_0000, 0, 1, 32'hFFFF_FFFD, 0, 0);
        idle("R10");
        step("R10", 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step("R10", 1, 1, 1, 32'h0000_0003, 0, 1, 32'hFFFF_FFF9, 0, 0);
        idle("R10");
        // R11: entry and return together, with an invalid and a valid code
        step("R11", 1, 0, 1, 0, 1, 1, 32'h1234_5678, 0, 0);
        step("R11", 1, 0, 1, 0, 0, 1, 32'hFFFF_FFFD, 0, 0);
        step("R11", 1, 0, 1, 0, 1, 1, 32'hFFFF_FFF9, 0, 0);
        idle("R11");
        // R1: reset again restores defaults
        rst = 1;
        @(posedge clk);
        m_hand = 0; m_sel = 0; m_tmpl = 0; m_cap = 0; m_fault = 0; m_bad = 0;
        m_main = 0; m_proc = 0;
        @(negedge clk);
        rst = 0;
        compare_regs("R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule